// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis Controller

This block decides, from the fill level of a 64-entry receive FIFO, when the remote transmitter must stop and when it may start again. One 8-bit threshold byte holds two packed 4-bit fields. The upper-nibble field sets the restore level. The lower-nibble field sets the halt level. Each field is scaled by four. The gap between the two levels forms a hysteresis window, so a FIFO level that hovers near one edge does not toggle the flow state.

The block drives an active-low ready-to-send line for hardware flow control. For software flow control it raises one-cycle requests that ask a separate transmitter to send the stop (XOFF) or resume (XON) character. The block sees only the FIFO level. It does not store characters, send them or match them.

The threshold byte is written over a byte-wide bus with a write strobe. A write takes effect only while both of two qualifier enables are high. Nothing checks that the halt level lies above the restore level. Software should program valid thresholds before it turns flow control on.

Top module: `rxfc_hysteresis`

## Requirements
- R1: After reset the threshold byte is 0x00, rts_n is low, and xoff_req and xon_req are low. With byte 0x00 the halt level is 0, so a FIFO level of 0 with flow control on already halts in the next cycle.
- R2: A write with wr_en high updates the threshold byte at the clock edge only if ext_en and acc_en are both 1. Under any other combination of the two enables the write is ignored and both levels keep their old values.
- R3: The halt level is 4 × wr_data[3:0] and the restore level is 4 × wr_data[7:4], giving levels 0 to 60 in steps of 4. A new byte first acts on the compare in the cycle after the write edge.
- R4: With flow control on and the state "allowed", a FIFO level greater than or equal to the halt level sets the state to "halted" at the next clock edge.
- R5: With flow control on and the state "halted", a FIFO level less than or equal to the restore level sets the state to "allowed" at the next clock edge.
- R6: With flow control on, a level above the restore level keeps a halted state halted. A level below the halt level keeps an allowed state allowed.
- R7: xoff_req is high for exactly the one cycle after an edge that enters "halted", and only if sw_fc_en was 1 at that edge. xon_req behaves the same way on an edge that enters "allowed".
- R8: rts_n is high only while the state is "halted" and hw_fc_en is 1. Otherwise rts_n is low.
- R9: While hw_fc_en and sw_fc_en are both 0, the state returns to "allowed" at the next edge and no request is raised.
- R10: If the halt level is not above the restore level, the rules of R4 and R5 apply without any correction. For example, halt 8 and restore 20 with a steady level of 10 make the state alternate every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the threshold byte |
| wr_data | input | 8 | Threshold byte: [7:4] restore field, [3:0] halt field |
| ext_en | input | 1 | Enhanced-function enable qualifier for writes |
| acc_en | input | 1 | Register-access enable qualifier for writes |
| hw_fc_en | input | 1 | Hardware (rts_n) flow-control enable |
| sw_fc_en | input | 1 | Software (XON/XOFF request) flow-control enable |
| rx_level | input | 7 | Current receive FIFO fill level, 0 to 64 |
| rts_n | output | 1 | Active-low ready-to-send; high asks the remote side to stop |
| xoff_req | output | 1 | One-cycle request to send the stop character |
| xon_req | output | 1 | One-cycle request to send the resume character |

## Verification
The bench builds the block with its default FIFO depth of 64 and a level step of 4. Every one of the 256 threshold bytes therefore fits the 7-bit level input. For each byte the FIFO level ramps from 0 to 64 and back down. This reaches each halt and restore edge exactly, including the level-0 and level-60 ends and every misordered pair. Further runs cover each disallowed enable combination during a write and each hardware/software enable combination.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
   localparam int FLD_W = 4;

   typedef struct packed {
      logic [FLD_W-1:0] resume_f;
      logic [FLD_W-1:0] trip_f;
   } rxfc_cfg_t;
endpackage

// File: rtl/rxfc_cfg_reg.sv
module rxfc_cfg_reg
   import rxfc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2*FLD_W-1:0] wr_data,
   input  logic              ext_en,
   input  logic              acc_en,
   output rxfc_cfg_t         cfg_o
);
   logic wr_ok;
   assign wr_ok = wr_en & ext_en & acc_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_o <= '0;
      else if (wr_ok)
         cfg_o <= rxfc_cfg_t'(wr_data);
   end

   // R2
   cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ext_en && acc_en) |=> $stable(cfg_o));
endmodule

// File: rtl/rxfc_level_cmp.sv
module rxfc_level_cmp
   import rxfc_pkg::*;
#(
   parameter int CNT_W    = 7,
   parameter int LVL_STEP = 4
) (
   input  rxfc_cfg_t         cfg_i,
   input  logic [CNT_W-1:0]  level_i,
   output logic              trip_hit,
   output logic              rel_hit
);
   localparam bit STEP_POW2 = (LVL_STEP & (LVL_STEP - 1)) == 0;
   localparam int STEP_SH   = $clog2(LVL_STEP);

   logic [CNT_W-1:0] trip_lvl;
   logic [CNT_W-1:0] rel_lvl;

   generate
      if (STEP_POW2) begin : g_shift
         assign trip_lvl = CNT_W'(cfg_i.trip_f)   << STEP_SH;
         assign rel_lvl  = CNT_W'(cfg_i.resume_f) << STEP_SH;
      end else begin : g_mult
         assign trip_lvl = CNT_W'(int'(cfg_i.trip_f)   * LVL_STEP);
         assign rel_lvl  = CNT_W'(int'(cfg_i.resume_f) * LVL_STEP);
      end
   endgenerate

   assign trip_hit = level_i >= trip_lvl;
   assign rel_hit  = level_i <= rel_lvl;
endmodule

// File: rtl/rxfc_flow_fsm.sv
module rxfc_flow_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_en,
   input  logic sw_en,
   input  logic trip_hit,
   input  logic rel_hit,
   output logic halted,
   output logic xoff_req,
   output logic xon_req
);
   logic fc_on;
   assign fc_on = hw_en | sw_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted   <= 1'b0;
         xoff_req <= 1'b0;
         xon_req  <= 1'b0;
      end else begin
         xoff_req <= 1'b0;
         xon_req  <= 1'b0;
         if (!fc_on) begin
            halted <= 1'b0;
         end else if (!halted && trip_hit) begin
            halted   <= 1'b1;
            xoff_req <= sw_en;
         end else if (halted && rel_hit) begin
            halted  <= 1'b0;
            xon_req <= sw_en;
         end
      end
   end

   // R4
   halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_on && !halted && trip_hit) |=> halted);
   // R5
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_on && halted && rel_hit) |=> !halted);
   // R6
   hold_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_on && halted && !rel_hit) |=> halted);
   // R6
   hold_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_on && !halted && !trip_hit) |=> !halted);
   // R7
   xoff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_req |-> (halted && !xon_req));
   // R7
   xon_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xon_req |-> !halted);
   // R9
   fc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fc_on |=> (!halted && !xoff_req && !xon_req));
endmodule

// File: rtl/rxfc_hysteresis.sv
module rxfc_hysteresis
   import rxfc_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int LVL_STEP   = 4,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2*FLD_W-1:0] wr_data,
   input  logic              ext_en,
   input  logic              acc_en,
   input  logic              hw_fc_en,
   input  logic              sw_fc_en,
   input  logic [CNT_W-1:0]  rx_level,
   output logic              rts_n,
   output logic              xoff_req,
   output logic              xon_req
);
   localparam int MAX_LVL = LVL_STEP * ((1 << FLD_W) - 1);

   initial begin
      step_param_chk: assert (LVL_STEP >= 1)
         else $error("level step must be at least 1");
      depth_param_chk: assert (MAX_LVL <= FIFO_DEPTH)
         else $error("largest threshold exceeds FIFO depth");
   end

   rxfc_cfg_t cfg;
   logic      trip_hit, rel_hit, halted;

   rxfc_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ext_en  (ext_en),
      .acc_en  (acc_en),
      .cfg_o   (cfg)
   );

   rxfc_level_cmp #(.CNT_W(CNT_W), .LVL_STEP(LVL_STEP)) u_cmp (
      .cfg_i    (cfg),
      .level_i  (rx_level),
      .trip_hit (trip_hit),
      .rel_hit  (rel_hit)
   );

   rxfc_flow_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_en    (hw_fc_en),
      .sw_en    (sw_fc_en),
      .trip_hit (trip_hit),
      .rel_hit  (rel_hit),
      .halted   (halted),
      .xoff_req (xoff_req),
      .xon_req  (xon_req)
   );

   assign rts_n = halted & hw_fc_en;

   // R8
   rts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rts_n |-> hw_fc_en);
endmodule

// File: tb/rxfc_hysteresis_test.sv
`timescale 1ns/1ps
module rxfc_hysteresis_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       ext_en = 1'b0;
   logic       acc_en = 1'b0;
   logic       hw_fc_en = 1'b0;
   logic       sw_fc_en = 1'b0;
   logic [6:0] rx_level = 7'd0;
   logic       rts_n, xoff_req, xon_req;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_cfg;
   logic       m_halt, m_xoff, m_xon;

   always #4 clk = ~clk;

   rxfc_hysteresis uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ext_en(ext_en), .acc_en(acc_en), .hw_fc_en(hw_fc_en),
      .sw_fc_en(sw_fc_en), .rx_level(rx_level),
      .rts_n(rts_n), .xoff_req(xoff_req), .xon_req(xon_req)
   );

   // Reference model built from the requirements
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cfg <= 8'h00; m_halt <= 1'b0; m_xoff <= 1'b0; m_xon <= 1'b0;
      end else begin
         m_xoff <= 1'b0;
         m_xon  <= 1'b0;
         if (!(hw_fc_en || sw_fc_en))
            m_halt <= 1'b0;
         else if (!m_halt && int'(rx_level) >= int'(m_cfg[3:0]) * 4) begin
            m_halt <= 1'b1; m_xoff <= sw_fc_en;
         end else if (m_halt && int'(rx_level) <= int'(m_cfg[7:4]) * 4) begin
            m_halt <= 1'b0; m_xon <= sw_fc_en;
         end
         if (wr_en && ext_en && acc_en) m_cfg <= wr_data;
      end
   end

   task automatic chk(input string tag);
      logic e_rts;
      e_rts = m_halt & hw_fc_en;
      checks++;
      if (rts_n !== e_rts || xoff_req !== m_xoff || xon_req !== m_xon) begin
         errors++;
         $display("FAIL %s: level=%0d cfg=%02h rts_n/xoff/xon actual=%b%b%b expected=%b%b%b",
                  tag, rx_level, m_cfg, rts_n, xoff_req, xon_req, e_rts, m_xoff, m_xon);
      end
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      @(negedge clk);
      chk(tag);
   endtask

   task automatic write_cfg(input logic [7:0] v, input logic e, input logic a, input string tag);
      wr_data = v; ext_en = e; acc_en = a; wr_en = 1'b1;
      tick(tag);
      wr_en = 1'b0; ext_en = 1'b0; acc_en = 1'b0;
   endtask

   task automatic ramp(input string tag);
      for (int l = 0; l <= 64; l++) begin rx_level = 7'(l); tick(tag); end
      for (int l = 64; l >= 0; l--) begin rx_level = 7'(l); tick(tag); end
   endtask

   initial begin
      #50000000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release");
      // R1: byte 0x00 means halt level 0, so level 0 halts
      hw_fc_en = 1'b1; sw_fc_en = 1'b1; rx_level = 7'd0;
      tick("R1 zero halt level");
      tick("R10 zero levels alternate");
      tick("R10 zero levels alternate");

      // R3 R4 R5 R6 R7 R10: full sweep of all threshold bytes
      for (int b = 0; b < 256; b++) begin
         hw_fc_en = 1'b0; sw_fc_en = 1'b0;
         write_cfg(8'(b), 1'b1, 1'b1, "R2 write accepted");
         rx_level = 7'd0;
         tick("R9 off settle");
         hw_fc_en = 1'b1; sw_fc_en = 1'b1;
         ramp((b[7:4] >= b[3:0]) ? "R10 misordered sweep" : "R4 R5 R6 sweep");
      end

      // R2: disallowed enable combinations leave byte 0x28 in place
      for (int c = 0; c < 3; c++) begin
         hw_fc_en = 1'b0; sw_fc_en = 1'b0;
         write_cfg(8'h28, 1'b1, 1'b1, "R2 setup");
         write_cfg(8'h01, c[0], c[1], "R2 ignored write");
         hw_fc_en = 1'b1; sw_fc_en = 1'b1;
         ramp("R2 ignored write keeps levels");
      end

      // R7 R8 R9: each hardware/software enable pair
      hw_fc_en = 1'b0; sw_fc_en = 1'b0;
      write_cfg(8'h3A, 1'b1, 1'b1, "R3 setup");
      for (int m = 0; m < 4; m++) begin
         hw_fc_en = m[0]; sw_fc_en = m[1];
         ramp(m == 0 ? "R9 flow control off" : (m == 1 ? "R8 hardware only" : "R7 software requests"));
      end

      // R9: turning off while halted returns to allowed with no request
      hw_fc_en = 1'b1; sw_fc_en = 1'b1; rx_level = 7'd50;
      tick("R4 halt before off");
      hw_fc_en = 1'b0; sw_fc_en = 1'b0;
      tick("R9 off while halted");
      tick("R9 stays allowed");

      // R10: halt 8, restore 20, steady level 10 alternates
      write_cfg(8'h52, 1'b1, 1'b1, "R10 setup");
      hw_fc_en = 1'b1; sw_fc_en = 1'b1; rx_level = 7'd10;
      for (int k = 0; k < 6; k++) tick("R10 alternating state");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule